// File: doc/BRIEF.md
# Converter Start Trigger Selector

This block produces the start-of-conversion pulse for one analog-to-digital converter. It chooses one of up to sixteen hardware trigger sources: an asynchronous external start pin, a set of PWM channels that each offer four event lines, a set of timer event lines, and the end-of-conversion events of the two converters. It qualifies the chosen source, waits a programmed delay, and then emits a single-cycle start pulse to the conversion sequencer.

Each converter uses its own instance. The PWM and timer units sit outside the block and supply only their event lines. The external pin passes through a synchronizer. Its edge qualification can be set to rising, falling or both edges. Every other source line is a synchronous signal, and a trigger is taken from its rising edge. A master hardware-trigger enable gates the whole path.

Top module: `trig_start_gen`

## Requirements
- R1: After reset `conv_start` is low, and no delay is pending.
- R2: `src_sel` picks the trigger source. Code 0 is the external pin. Codes 1 to 6 are PWM channels 0 to 5. Codes 7 to 9 are timers 0 to 2 (`tmr_evt` bit 0 to 2). Code 10 is `eoc0_evt` and code 11 is `eoc1_evt`. Only the selected source can cause a start.
- R3: For a PWM source, `pwm_evt_sel` picks the line `pwm_evt[4*ch + sel]`. The codes are 0 falling, 1 counter centre, 2 rising and 3 period. The other lines of that channel have no effect.
- R4: The external pin goes through a two-flop synchronizer and then an edge detector. `pin_edge_sel` codes are 0 rising, 1 falling, 2 either edge and 3 never. With zero delay, a pin change set up before clock edge A gives `conv_start` high in the cycle after edge A+2.
- R5: Non-pin source lines are qualified on their rising edge. A line held high gives exactly one trigger.
- R6: With delay value N, the pulse comes 4×N clocks after the trigger. A rising edge sampled at clock edge E gives `conv_start` high in the cycle after edge E+4N. N = 0 means no added delay.
- R7: While `hw_trig_en` is low, no trigger is accepted. Clearing it also abandons a pending delay, so no pulse follows.
- R8: Source codes 12 to 15 never cause a start.
- R9: A trigger that arrives while a delay count is running is ignored. It neither restarts nor adds a pulse.
- R10: Each accepted trigger gives exactly one `conv_start` pulse, one cycle wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hw_trig_en | input | 1 | Hardware trigger enable |
| src_sel | input | 4 | Trigger source code |
| pwm_evt_sel | input | 2 | PWM event type select |
| pin_edge_sel | input | 2 | External pin edge qualification |
| delay_val | input | DLY_W | Start delay in units of DLY_SCALE clocks |
| ext_start_pin | input | 1 | Asynchronous external start pin |
| pwm_evt | input | NUM_PWM*PWM_EVTS | PWM event lines, four per channel |
| tmr_evt | input | NUM_TMR | Timer event lines |
| eoc0_evt | input | 1 | End-of-conversion event, converter 0 |
| eoc1_evt | input | 1 | End-of-conversion event, converter 1 |
| conv_start | output | 1 | Single-cycle conversion start pulse |

## Verification
Two cases are hard to reach from the ports. In one, a second trigger arrives inside a running delay window. In the other, the enable drops part-way through that window. In both, the delay must be long enough that the event lands strictly between the trigger and the due pulse. The bench uses a delay of two units (eight clocks), fires a second timer event three cycles after the first, and checks that only the original pulse appears on its original cycle. It also clears the enable four cycles into the window and checks that no pulse appears afterwards. A maximum delay of 255 tests the top of the counter range.

// File: rtl/trig_sel_pkg.sv
package trig_sel_pkg;
   localparam int SRC_W = 4;

   typedef enum logic [1:0] {
      PIN_RISE = 2'd0,
      PIN_FALL = 2'd1,
      PIN_BOTH = 2'd2,
      PIN_NONE = 2'd3
   } pin_edge_e;

   typedef enum logic [1:0] {
      PEV_FALL   = 2'd0,
      PEV_CENTRE = 2'd1,
      PEV_RISE   = 2'd2,
      PEV_PERIOD = 2'd3
   } pwm_evt_e;
endpackage

// File: rtl/trig_pin_sync.sv
module trig_pin_sync
   import trig_sel_pkg::*;
#(
   parameter int STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       pin_i,
   input  logic [1:0] edge_sel,
   output logic       hit_o
);
   logic [STAGES:0] sh;
   logic            cur, prv;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh <= '0;
      else        sh <= {sh[STAGES-1:0], pin_i};
   end

   assign cur = sh[STAGES-1];
   assign prv = sh[STAGES];

   always_comb begin
      unique case (pin_edge_e'(edge_sel))
         PIN_RISE: hit_o = cur & ~prv;
         PIN_FALL: hit_o = ~cur & prv;
         PIN_BOTH: hit_o = cur ^ prv;
         default:  hit_o = 1'b0;
      endcase
   end
endmodule

// File: rtl/trig_evt_edge.sv
module trig_evt_edge #(
   parameter int N = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] lines_i,
   output logic [N-1:0] rise_o
);
   logic [N-1:0] prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= '0;
      else        prev <= lines_i;
   end

   assign rise_o = lines_i & ~prev;
endmodule

// File: rtl/trig_delay.sv
module trig_delay #(
   parameter int DLY_W     = 8,
   parameter int DLY_SCALE = 4,
   parameter int CNT_W     = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en_i,
   input  logic             hit_i,
   input  logic [DLY_W-1:0] dly_i,
   output logic             start_o,
   output logic             busy_o,
   output logic [CNT_W-1:0] cnt_o
);
   logic [CNT_W-1:0] load;

   assign load = CNT_W'(DLY_SCALE) * CNT_W'(dly_i) - CNT_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         start_o <= 1'b0;
         busy_o  <= 1'b0;
         cnt_o   <= '0;
      end else begin
         start_o <= 1'b0;
         if (!en_i) begin
            busy_o <= 1'b0;
            cnt_o  <= '0;
         end else if (busy_o) begin
            if (cnt_o == '0) begin
               start_o <= 1'b1;
               busy_o  <= 1'b0;
            end else begin
               cnt_o <= cnt_o - CNT_W'(1);
            end
         end else if (hit_i) begin
            if (dly_i == '0) begin
               start_o <= 1'b1;
            end else begin
               busy_o <= 1'b1;
               cnt_o  <= load;
            end
         end
      end
   end
endmodule

// File: rtl/trig_start_gen.sv
module trig_start_gen
   import trig_sel_pkg::*;
#(
   parameter int NUM_PWM     = 6,
   parameter int PWM_EVTS    = 4,
   parameter int NUM_TMR     = 3,
   parameter int DLY_W       = 8,
   parameter int DLY_SCALE   = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         hw_trig_en,
   input  logic [3:0]                   src_sel,
   input  logic [1:0]                   pwm_evt_sel,
   input  logic [1:0]                   pin_edge_sel,
   input  logic [DLY_W-1:0]             delay_val,
   input  logic                         ext_start_pin,
   input  logic [NUM_PWM*PWM_EVTS-1:0]  pwm_evt,
   input  logic [NUM_TMR-1:0]           tmr_evt,
   input  logic                         eoc0_evt,
   input  logic                         eoc1_evt,
   output logic                         conv_start
);
   localparam int SRC_PWM0 = 1;
   localparam int SRC_TMR0 = SRC_PWM0 + NUM_PWM;
   localparam int SRC_EOC0 = SRC_TMR0 + NUM_TMR;
   localparam int SRC_EOC1 = SRC_EOC0 + 1;
   localparam int NUM_SRC  = SRC_EOC1 + 1;
   localparam int NUM_CODE = 1 << SRC_W;
   localparam int NUM_LINE = NUM_PWM * PWM_EVTS + NUM_TMR + 2;
   localparam int CNT_W    = $clog2(DLY_SCALE * ((1 << DLY_W) - 1) + 1);

   generate
      if (NUM_SRC > NUM_CODE) begin : g_bad_src
         $error("trig_start_gen: sources exceed source code space");
      end
      if (PWM_EVTS != 4) begin : g_bad_evt
         $error("trig_start_gen: PWM event select needs four lines per channel");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("trig_start_gen: synchronizer needs at least two stages");
      end
      if (DLY_SCALE < 1) begin : g_bad_scale
         $error("trig_start_gen: delay scale must be positive");
      end
   endgenerate

   logic                pin_hit;
   logic [NUM_LINE-1:0] line_rise;
   logic [NUM_CODE-1:0] src_hit;
   logic                sel_hit;
   logic                dly_busy;
   logic [CNT_W-1:0]    dly_cnt;

   trig_pin_sync #(.STAGES(SYNC_STAGES)) pin_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .pin_i    (ext_start_pin),
      .edge_sel (pin_edge_sel),
      .hit_o    (pin_hit)
   );

   trig_evt_edge #(.N(NUM_LINE)) edge_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .lines_i ({eoc1_evt, eoc0_evt, tmr_evt, pwm_evt}),
      .rise_o  (line_rise)
   );

   assign src_hit[0] = pin_hit;

   genvar gp, gt, gr;
   generate
      for (gp = 0; gp < NUM_PWM; gp++) begin : g_pwm
         logic [PWM_EVTS-1:0] grp;
         assign grp                  = line_rise[gp*PWM_EVTS +: PWM_EVTS];
         assign src_hit[SRC_PWM0+gp] = grp[pwm_evt_sel];
      end
      for (gt = 0; gt < NUM_TMR; gt++) begin : g_tmr
         assign src_hit[SRC_TMR0+gt] = line_rise[NUM_PWM*PWM_EVTS + gt];
      end
      for (gr = NUM_SRC; gr < NUM_CODE; gr++) begin : g_rsvd
         assign src_hit[gr] = 1'b0;
      end
   endgenerate

   assign src_hit[SRC_EOC0] = line_rise[NUM_LINE-2];
   assign src_hit[SRC_EOC1] = line_rise[NUM_LINE-1];

   assign sel_hit = hw_trig_en & src_hit[src_sel];

   trig_delay #(.DLY_W(DLY_W), .DLY_SCALE(DLY_SCALE), .CNT_W(CNT_W)) dly_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .en_i    (hw_trig_en),
      .hit_i   (sel_hit),
      .dly_i   (delay_val),
      .start_o (conv_start),
      .busy_o  (dly_busy),
      .cnt_o   (dly_cnt)
   );
endmodule

// File: rtl/trig_start_gen_chk.sv
module trig_start_gen_chk #(
   parameter int DLY_W = 8,
   parameter int CNT_W = 10
) (
   input logic             clk,
   input logic             rst_n,
   input logic             hw_trig_en,
   input logic [3:0]       src_sel,
   input logic [DLY_W-1:0] delay_val,
   input logic             conv_start,
   input logic             busy,
   input logic [CNT_W-1:0] cnt
);
   // R7
   gate_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !hw_trig_en |=> !conv_start);

   // R8
   rsvd_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (src_sel >= 4'd12 && !busy) |=> !conv_start);

   // R9
   no_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && hw_trig_en && cnt != '0) |=> (busy && cnt == CNT_W'($past(cnt) - 1'b1)));

   // R6
   zero_dly_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && delay_val == '0) |=> !busy);

   // R6
   expire_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && hw_trig_en && cnt == '0) |=> (conv_start && !busy));

   // R1
   reset_chk: assert property (@(posedge clk)
      $rose(rst_n) |-> (!conv_start && !busy));
endmodule

bind trig_start_gen trig_start_gen_chk #(.DLY_W(DLY_W), .CNT_W(CNT_W)) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .hw_trig_en (hw_trig_en),
   .src_sel    (src_sel),
   .delay_val  (delay_val),
   .conv_start (conv_start),
   .busy       (dly_busy),
   .cnt        (dly_cnt)
);

// File: tb/trig_start_gen_tb_top.sv
module trig_start_gen_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        hw_en = 1'b0;
   logic [3:0]  src = '0;
   logic [1:0]  psel = '0;
   logic [1:0]  esel = '0;
   logic [7:0]  dly = '0;
   logic        pin = 1'b0;
   logic [23:0] pwm = '0;
   logic [2:0]  tmr = '0;
   logic        eoc0 = 1'b0;
   logic        eoc1 = 1'b0;
   logic        conv_start;

   int total = 0;
   int bad   = 0;

   always #10 clk = ~clk;

   trig_start_gen dut_i (
      .clk           (clk),
      .rst_n         (rst_n),
      .hw_trig_en    (hw_en),
      .src_sel       (src),
      .pwm_evt_sel   (psel),
      .pin_edge_sel  (esel),
      .delay_val     (dly),
      .ext_start_pin (pin),
      .pwm_evt       (pwm),
      .tmr_evt       (tmr),
      .eoc0_evt      (eoc0),
      .eoc1_evt      (eoc1),
      .conv_start    (conv_start)
   );

   // kind: 0 pin rise, 1 pin fall, 2 pwm line, 3 timer line, 4 eoc0, 5 eoc1
   typedef struct packed {
      logic [3:0] src;
      logic [1:0] psel;
      logic [1:0] esel;
      logic [7:0] dly;
      logic [2:0] kind;
      logic [3:0] idx;
      logic [1:0] evt;
      logic       fire;
   } vec_t;

   localparam int NV = 20;
   localparam vec_t VECS [NV] = '{
      '{4'd0,  2'd0, 2'd0, 8'd0,   3'd0, 4'd0, 2'd0, 1'b1},
      '{4'd0,  2'd0, 2'd1, 8'd0,   3'd1, 4'd0, 2'd0, 1'b1},
      '{4'd0,  2'd0, 2'd2, 8'd1,   3'd0, 4'd0, 2'd0, 1'b1},
      '{4'd0,  2'd0, 2'd2, 8'd0,   3'd1, 4'd0, 2'd0, 1'b1},
      '{4'd0,  2'd0, 2'd1, 8'd0,   3'd0, 4'd0, 2'd0, 1'b0},
      '{4'd0,  2'd0, 2'd3, 8'd0,   3'd0, 4'd0, 2'd0, 1'b0},
      '{4'd1,  2'd0, 2'd0, 8'd0,   3'd2, 4'd0, 2'd0, 1'b1},
      '{4'd6,  2'd3, 2'd0, 8'd2,   3'd2, 4'd5, 2'd3, 1'b1},
      '{4'd3,  2'd1, 2'd0, 8'd0,   3'd2, 4'd2, 2'd1, 1'b1},
      '{4'd3,  2'd1, 2'd0, 8'd0,   3'd2, 4'd2, 2'd2, 1'b0},
      '{4'd2,  2'd0, 2'd0, 8'd0,   3'd2, 4'd0, 2'd0, 1'b0},
      '{4'd7,  2'd0, 2'd0, 8'd0,   3'd3, 4'd0, 2'd0, 1'b1},
      '{4'd9,  2'd0, 2'd0, 8'd1,   3'd3, 4'd2, 2'd0, 1'b1},
      '{4'd8,  2'd0, 2'd0, 8'd0,   3'd3, 4'd2, 2'd0, 1'b0},
      '{4'd10, 2'd0, 2'd0, 8'd0,   3'd4, 4'd0, 2'd0, 1'b1},
      '{4'd11, 2'd0, 2'd0, 8'd0,   3'd5, 4'd0, 2'd0, 1'b1},
      '{4'd11, 2'd0, 2'd0, 8'd0,   3'd4, 4'd0, 2'd0, 1'b0},
      '{4'd12, 2'd0, 2'd0, 8'd0,   3'd4, 4'd0, 2'd0, 1'b0},
      '{4'd15, 2'd0, 2'd0, 8'd0,   3'd3, 4'd0, 2'd0, 1'b0},
      '{4'd7,  2'd0, 2'd0, 8'd255, 3'd3, 4'd0, 2'd0, 1'b1}
   };

   task automatic check(input logic ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic setup(input logic [3:0] s, input logic [1:0] p, input logic [1:0] e,
                        input logic [7:0] d, input logic pre);
      @(negedge clk);
      hw_en = 1'b0; src = s; psel = p; esel = e; dly = d; pin = pre;
      pwm = '0; tmr = '0; eoc0 = 1'b0; eoc1 = 1'b0;
      repeat (5) @(negedge clk);
      hw_en = 1'b1;
      @(negedge clk);
   endtask

   task automatic run_vec(input vec_t v);
      int first, cnt, expc, w;
      string tag;
      setup(v.src, v.psel, v.esel, v.dly, v.kind == 3'd1);
      case (v.kind)
         3'd0: pin = 1'b1;
         3'd1: pin = 1'b0;
         3'd2: pwm[v.idx*4 + v.evt] = 1'b1;
         3'd3: tmr[v.idx] = 1'b1;
         3'd4: eoc0 = 1'b1;
         default: eoc1 = 1'b1;
      endcase
      w = 4 * v.dly + 10;
      first = -1;
      cnt = 0;
      for (int i = 1; i <= w; i++) begin
         @(negedge clk);
         if (conv_start) begin
            cnt++;
            if (first < 0) first = i;
         end
         if (i == 1) begin
            pwm = '0; tmr = '0; eoc0 = 1'b0; eoc1 = 1'b0;
         end
      end
      expc = (v.kind < 3'd2 ? 3 : 1) + 4 * v.dly;
      if (v.src >= 4'd12)      tag = "R8 reserved code";
      else if (v.kind < 3'd2)  tag = "R4 pin edge";
      else if (v.kind == 3'd2) tag = "R3 pwm event";
      else                     tag = "R2 source select";
      if (v.fire) begin
         check(first == expc, {tag, " / R6 pulse cycle"}, first, expc);
         check(cnt == 1, {tag, " / R10 single pulse"}, cnt, 1);
      end else begin
         check(cnt == 0, tag, cnt, 0);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      $display("FAIL watchdog R1 actual=%0d expected=%0d", 1, 0);
      total++;
      bad++;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int cnt, first;
      // R1 reset state
      repeat (3) @(negedge clk);
      check(conv_start == 1'b0, "R1 during reset", conv_start, 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      check(conv_start == 1'b0, "R1 after reset", conv_start, 0);

      for (int k = 0; k < NV; k++) run_vec(VECS[k]);

      // R5 held level gives one trigger
      setup(4'd7, 2'd0, 2'd0, 8'd0, 1'b0);
      tmr[0] = 1'b1;
      cnt = 0;
      for (int i = 1; i <= 15; i++) begin
         @(negedge clk);
         if (conv_start) cnt++;
      end
      tmr[0] = 1'b0;
      check(cnt == 1, "R5 held line", cnt, 1);

      // R9 retrigger inside delay window ignored
      setup(4'd7, 2'd0, 2'd0, 8'd2, 1'b0);
      tmr[0] = 1'b1;
      cnt = 0;
      first = -1;
      for (int i = 1; i <= 20; i++) begin
         @(negedge clk);
         if (conv_start) begin
            cnt++;
            if (first < 0) first = i;
         end
         if (i == 1 || i == 4) tmr[0] = 1'b0;
         if (i == 3) tmr[0] = 1'b1;
      end
      check(cnt == 1, "R9 retrigger count", cnt, 1);
      check(first == 9, "R9 retrigger timing", first, 9);

      // R7 enable dropped mid-delay
      setup(4'd7, 2'd0, 2'd0, 8'd2, 1'b0);
      tmr[0] = 1'b1;
      cnt = 0;
      for (int i = 1; i <= 15; i++) begin
         @(negedge clk);
         if (conv_start) cnt++;
         if (i == 1) tmr[0] = 1'b0;
         if (i == 4) hw_en = 1'b0;
      end
      check(cnt == 0, "R7 cancel pending", cnt, 0);

      // R7 event while disabled
      setup(4'd7, 2'd0, 2'd0, 8'd0, 1'b0);
      hw_en = 1'b0;
      tmr[0] = 1'b1;
      cnt = 0;
      for (int i = 1; i <= 6; i++) begin
         @(negedge clk);
         if (conv_start) cnt++;
         if (i == 1) tmr[0] = 1'b0;
      end
      check(cnt == 0, "R7 disabled", cnt, 0);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule